// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block loads a programmable device over a slave-serial configuration port. After a start pulse it holds the active-low program line low until the device pulls its init line low. It then releases the program line and waits for init to return high. Next it takes configuration data from a ready/valid word stream and sends each bit most-significant first as a four-step pattern on a clock/data pin pair. When the word marked last has been sent, it waits for the device's done line. Each of the three waits has its own timeout and its own error code. The status and code stay on the outputs until the next start.

Timeouts are counted in poll periods. `CYC_PER_MS` sets the length of one period in clock cycles, and `POLL_LIMIT` sets how many periods a wait may last. A short period can be chosen for simulation. `WORD_W` sets the width of the stream word. With `WORD_W = 1` an internal passthrough serializer is used, so an upstream bit decompressor can feed the block one bit at a time and stall it whenever it likes.

States: `ST_IDLE` (after reset), `ST_PROG` (program low, waiting for init low), `ST_RELEASE` (program high, waiting for init high), `ST_FETCH` (waiting for a bit), `ST_CLKLO`, `ST_SETD`, `ST_CLKHI`, `ST_RESTORE` (the four bit steps), `ST_AWAIT` (waiting for done) and `ST_END` (status held).

Transitions:
- From `ST_IDLE` or `ST_END`, start goes to `ST_PROG`.
- `ST_PROG` goes to `ST_RELEASE` when init is low, or to `ST_END` on timeout.
- `ST_RELEASE` goes to `ST_FETCH` when init is high, or to `ST_END` on timeout.
- `ST_FETCH` goes to `ST_CLKLO` when a bit is available.
- The bit steps run `ST_CLKLO`, `ST_SETD`, `ST_CLKHI`, `ST_RESTORE` in order.
- `ST_RESTORE` goes to `ST_AWAIT` after the last bit, to `ST_CLKLO` if another bit is ready, and otherwise to `ST_FETCH`.
- `ST_AWAIT` goes to `ST_END` when done is high or on timeout.

Top module: `cfgld_seq`

## Requirements
- R1: After reset, and whenever the block is not busy, `prog_n_o`, `cclk_o` and `din_o` are all high, `busy_o`, `fin_o` and `word_ready_o` are low.
- R2: The cycle after a start pulse is accepted, `busy_o` is high and `prog_n_o` is low while `cclk_o` and `din_o` stay high. A start pulse while busy has no effect on the sequence or on its timing.
- R3: If `cfg_init_i` stays high while the program line is low, the block stops with `fin_o` high, `code_o` = 1 and the program line high.
- R4: One cycle after `cfg_init_i` is seen low, `prog_n_o` returns high. No word is accepted until init is high again. If init stays low, the block stops with `code_o` = 2.
- R5: Each bit takes four consecutive cycles: (clock 0, data 1), (clock 0, data = bit), (clock 1, data = bit), (clock 1, data 1).
- R6: A word is accepted on a cycle where `word_valid_i` and `word_ready_o` are both high. Its bits go out on `din_o` from bit `WORD_W-1` down to bit 0, and consecutive words follow in order.
- R7: While no data is available the block holds `cclk_o` and `din_o` high and sends no clock edge.
- R8: After the last bit of the word flagged by `word_last_i`, the block waits for `cfg_done_i`. Done high gives `fin_o` with `code_o` = 0. A timeout gives `code_o` = 3.
- R9: A wait times out no sooner than `POLL_LIMIT*CYC_PER_MS` cycles and no later than two cycles after that.
- R10: Once finished, `fin_o` and `code_o` hold their values until the next start. That start drops `fin_o`, raises `busy_o` and runs a new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when not busy |
| cfg_init_i | input | 1 | Device init line, high = released |
| cfg_done_i | input | 1 | Device done line, high = configured |
| word_valid_i | input | 1 | Stream word valid |
| word_data_i | input | WORD_W | Stream word, sent most-significant bit first |
| word_last_i | input | 1 | Marks the final word of the image |
| word_ready_o | output | 1 | Block can accept a word |
| prog_n_o | output | 1 | Active-low program line |
| cclk_o | output | 1 | Configuration clock pin |
| din_o | output | 1 | Configuration data pin |
| busy_o | output | 1 | Sequence in progress |
| fin_o | output | 1 | Sequence finished, code valid |
| code_o | output | 2 | 0 ok, 1 init never fell, 2 init never rose, 3 done never rose |

## Verification
Some properties can be judged one cycle at a time, and the assertions check those on every cycle:
- the program line is low only while busy;
- the clock stays low for exactly two cycles;
- data is stable at each rising clock edge;
- the pins are high while idle;
- words are accepted only during the data phase;
- a finished status is held;
- a success code appears only after done was seen.

Other behaviour depends on whole sequences, and only the bench scenarios show it:
- the bit order within and across words;
- the four-step pin pattern for each bit;
- clock silence during stalls;
- the exact length of each timeout window;
- which of the three waits produced which code;
- a start being ignored while busy.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_RELEASE,
        ST_FETCH,
        ST_CLKLO,
        ST_SETD,
        ST_CLKHI,
        ST_RESTORE,
        ST_AWAIT,
        ST_END
    } cfg_state_e;

    typedef enum logic [1:0] {
        CODE_OK           = 2'd0,
        CODE_NO_INIT_LOW  = 2'd1,
        CODE_NO_INIT_HIGH = 2'd2,
        CODE_NO_DONE      = 2'd3
    } cfg_code_e;

endpackage

// File: rtl/cfgld_poll_timer.sv
module cfgld_poll_timer #(
    parameter int CYC_PER_MS = 50000,
    parameter int POLL_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int TW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] CYC_TOP  = CW'(CYC_PER_MS - 1);
    localparam logic [TW-1:0] TICK_TOP = TW'(POLL_LIMIT);

    logic [CW-1:0] cyc_q;
    logic [TW-1:0] ticks_q;

    // cycle counter inside a poll period, period counter saturates at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            ticks_q <= '0;
        end else if (restart) begin
            cyc_q   <= '0;
            ticks_q <= '0;
        end else if (ticks_q != TICK_TOP) begin
            if (cyc_q == CYC_TOP) begin
                cyc_q   <= '0;
                ticks_q <= ticks_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    assign expired = (ticks_q == TICK_TOP);

endmodule

// File: rtl/cfgld_serializer.sv
module cfgld_serializer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              take,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              bit_valid,
    output logic              bit_val,
    output logic              bit_last
);
    generate
        if (WORD_W == 1) begin : g_pass
            logic seen_last_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    seen_last_q <= 1'b0;
                end else if (!enable) begin
                    seen_last_q <= 1'b0;
                end else if (take && in_last) begin
                    seen_last_q <= 1'b1;
                end
            end

            assign bit_valid = enable && in_valid && !seen_last_q;
            assign bit_val   = in_data[0];
            assign bit_last  = in_last;
            assign in_ready  = take;
        end else begin : g_shift
            localparam int IW = $clog2(WORD_W);
            localparam logic [IW-1:0] LAST_IDX = IW'(WORD_W - 1);

            logic [WORD_W-1:0] sh_q;
            logic [IW-1:0]     idx_q;
            logic              full_q;
            logic              wlast_q;
            logic              seen_last_q;
            logic              load;

            assign in_ready = enable && !full_q && !seen_last_q;
            assign load     = in_valid && in_ready;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh_q        <= '0;
                    idx_q       <= '0;
                    full_q      <= 1'b0;
                    wlast_q     <= 1'b0;
                    seen_last_q <= 1'b0;
                end else if (!enable) begin
                    idx_q       <= '0;
                    full_q      <= 1'b0;
                    wlast_q     <= 1'b0;
                    seen_last_q <= 1'b0;
                end else if (load) begin
                    sh_q        <= in_data;
                    idx_q       <= '0;
                    full_q      <= 1'b1;
                    wlast_q     <= in_last;
                    seen_last_q <= in_last;
                end else if (take) begin
                    if (idx_q == LAST_IDX) begin
                        full_q <= 1'b0;
                    end else begin
                        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end

            assign bit_valid = full_q;
            assign bit_val   = sh_q[WORD_W-1];
            assign bit_last  = wlast_q && (idx_q == LAST_IDX);
        end
    endgenerate

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int CYC_PER_MS = 50000,
    parameter int POLL_LIMIT = 5,
    parameter int WORD_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cfg_init_i,
    input  logic              cfg_done_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    input  logic              word_last_i,
    output logic              word_ready_o,
    output logic              prog_n_o,
    output logic              cclk_o,
    output logic              din_o,
    output logic              busy_o,
    output logic              fin_o,
    output logic [1:0]        code_o
);
    cfg_state_e st, nxt;
    cfg_code_e  code_q, end_code;
    logic       cur_bit_q, cur_last_q;
    logic       stream_en, want, take;
    logic       bit_valid, bit_val, bit_last;
    logic       expired, restart;

    assign stream_en = st inside {ST_FETCH, ST_CLKLO, ST_SETD, ST_CLKHI, ST_RESTORE};
    assign want      = (st == ST_FETCH) || ((st == ST_RESTORE) && !cur_last_q);
    assign take      = want && bit_valid;
    assign restart   = (nxt != st);

    cfgld_poll_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (expired)
    );

    cfgld_serializer #(
        .WORD_W (WORD_W)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (stream_en),
        .take      (take),
        .in_valid  (word_valid_i),
        .in_data   (word_data_i),
        .in_last   (word_last_i),
        .in_ready  (word_ready_o),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .bit_last  (bit_last)
    );

    // next-state decode
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE, ST_END: if (start_i) nxt = ST_PROG;
            ST_PROG: begin
                if (!cfg_init_i)  nxt = ST_RELEASE;
                else if (expired) nxt = ST_END;
            end
            ST_RELEASE: begin
                if (cfg_init_i)   nxt = ST_FETCH;
                else if (expired) nxt = ST_END;
            end
            ST_FETCH:   if (bit_valid) nxt = ST_CLKLO;
            ST_CLKLO:   nxt = ST_SETD;
            ST_SETD:    nxt = ST_CLKHI;
            ST_CLKHI:   nxt = ST_RESTORE;
            ST_RESTORE: begin
                if (cur_last_q)     nxt = ST_AWAIT;
                else if (bit_valid) nxt = ST_CLKLO;
                else                nxt = ST_FETCH;
            end
            ST_AWAIT: begin
                if (cfg_done_i || expired) nxt = ST_END;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st)
            ST_PROG:    end_code = CODE_NO_INIT_LOW;
            ST_RELEASE: end_code = CODE_NO_INIT_HIGH;
            default:    end_code = cfg_done_i ? CODE_OK : CODE_NO_DONE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // bit in flight and finishing code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_bit_q  <= 1'b1;
            cur_last_q <= 1'b0;
            code_q     <= CODE_OK;
        end else begin
            if (nxt == ST_PROG && st != ST_PROG) begin
                cur_last_q <= 1'b0;
                code_q     <= CODE_OK;
            end else if (take) begin
                cur_bit_q  <= bit_val;
                cur_last_q <= bit_last;
            end
            if (nxt == ST_END && st != ST_END) code_q <= end_code;
        end
    end

    // pin and status outputs
    always_comb begin
        prog_n_o = (st != ST_PROG);
        cclk_o   = !(st == ST_CLKLO || st == ST_SETD);
        din_o    = (st == ST_SETD || st == ST_CLKHI) ? cur_bit_q : 1'b1;
        busy_o   = !(st == ST_IDLE || st == ST_END);
        fin_o    = (st == ST_END);
        code_o   = code_q;
    end

endmodule

// File: rtl/cfgld_seq_chk.sv
module cfgld_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       cfg_done_i,
    input logic       word_ready_o,
    input logic       prog_n_o,
    input logic       cclk_o,
    input logic       din_o,
    input logic       busy_o,
    input logic       fin_o,
    input logic [1:0] code_o
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (prog_n_o && cclk_o && din_o));

    // R2
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> busy_o);

    // R5
    clk_low_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cclk_o) |=> !cclk_o ##1 cclk_o);

    // R5
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(din_o));

    // R6
    ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready_o |-> (busy_o && prog_n_o));

    // R10
    fin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && !start_i) |=> (fin_o && $stable(code_o)));

    // R8
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fin_o) && code_o == 2'd0) |-> $past(cfg_done_i));

endmodule

bind cfgld_seq cfgld_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cfg_done_i   (cfg_done_i),
    .word_ready_o (word_ready_o),
    .prog_n_o     (prog_n_o),
    .cclk_o       (cclk_o),
    .din_o        (din_o),
    .busy_o       (busy_o),
    .fin_o        (fin_o),
    .code_o       (code_o)
);

// File: tb/tb_cfgld_seq.sv
`timescale 1ns/1ps
module tb_cfgld_seq;
    localparam int CPM = 10;
    localparam int PL  = 5;
    localparam int W   = 8;
    localparam int TMO = CPM * PL;
    localparam int NV  = 6;
    // bit 8 = last flag, bits 7:0 = word
    localparam logic [8:0] VEC [0:NV-1] = '{9'h0FF, 9'h020, 9'h0A5, 9'h000, 9'h03C, 9'h181};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cfg_init_i = 1'b1;
    logic cfg_done_i = 1'b0;
    logic word_valid_i = 1'b0;
    logic [W-1:0] word_data_i = '0;
    logic word_last_i = 1'b0;
    logic word_ready_o, prog_n_o, cclk_o, din_o, busy_o, fin_o;
    logic [1:0] code_o;

    int n_chk = 0;
    int n_fail = 0;
    int ncap = 0;
    int step_err = 0;
    logic cap [0:255];
    logic [2:0] hc = 3'b111;
    logic [2:0] hd = 3'b111;
    logic pend = 1'b0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    cfgld_seq #(.CYC_PER_MS(CPM), .POLL_LIMIT(PL), .WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_init_i(cfg_init_i),
        .cfg_done_i(cfg_done_i), .word_valid_i(word_valid_i), .word_data_i(word_data_i),
        .word_last_i(word_last_i), .word_ready_o(word_ready_o), .prog_n_o(prog_n_o),
        .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o), .fin_o(fin_o), .code_o(code_o)
    );

    // pin monitor: records the bit at each clock rise and checks the 4-step pattern (R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                if (!(cclk_o && din_o)) step_err++;
                pend = 1'b0;
            end
            if (cclk_o && !hc[0]) begin
                cap[ncap[7:0]] = din_o;
                ncap++;
                if (!(hd[0] == din_o && !hc[1] && hd[1] && hc[2] && hd[2])) step_err++;
                pend = 1'b1;
            end
            hc = {hc[1:0], cclk_o};
            hd = {hd[1:0], din_o};
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic send_word(input logic [W-1:0] d, input logic l);
        @(negedge clk);
        word_valid_i = 1'b1; word_data_i = d; word_last_i = l;
        while (!word_ready_o) @(negedge clk);
        @(negedge clk);
        word_valid_i = 1'b0; word_last_i = 1'b0;
    endtask

    task automatic wait_fin(output int n, input int restart_at);
        n = 0;
        while (!fin_o && n < 400) begin
            @(negedge clk);
            n++;
            if (n == restart_at) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        int n;
        logic [W-1:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(prog_n_o && cclk_o && din_o, "R1 pins high", {prog_n_o, cclk_o, din_o}, 7);
        chk(!busy_o && !fin_o && !word_ready_o, "R1 status low", {busy_o, fin_o, word_ready_o}, 0);

        // ---- full load ----
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o && !prog_n_o && cclk_o && din_o, "R2 program low",
            {busy_o, prog_n_o, cclk_o, din_o}, 11);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!prog_n_o && busy_o, "R2 start while busy", prog_n_o, 0);
        cfg_init_i = 1'b0;
        @(negedge clk);
        chk(prog_n_o == 1'b1, "R4 program released", prog_n_o, 1);
        repeat (3) @(negedge clk);
        chk(!word_ready_o, "R4 no data before init high", word_ready_o, 0);
        cfg_init_i = 1'b1;
        ncap = 0; step_err = 0;
        for (int i = 0; i < NV; i++) begin
            repeat (i) @(negedge clk);
            send_word(VEC[i][7:0], VEC[i][8]);
            repeat (4 * W + 4) @(negedge clk);
            // R7 stall: pins high, no further clock edges
            chk(cclk_o && din_o, "R7 idle pins during stall", {cclk_o, din_o}, 3);
            chk(ncap == W * (i + 1), "R6 bit count", ncap, W * (i + 1));
            for (int k = 0; k < W; k++) got[W-1-k] = cap[W * i + k];
            chk(got == VEC[i][7:0], "R6 MSB-first word", got, VEC[i][7:0]);
        end
        chk(step_err == 0, "R5 four-step pattern", step_err, 0);
        chk(busy_o && !fin_o && !word_ready_o, "R8 waiting for done", {busy_o, fin_o, word_ready_o}, 4);
        cfg_done_i = 1'b1;
        @(negedge clk);
        chk(fin_o && !busy_o && code_o == 2'd0, "R8 success code", code_o, 0);
        cfg_done_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(fin_o && code_o == 2'd0, "R10 status held", {fin_o, code_o}, 4);

        // ---- init never falls, with an ignored restart ----
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o && !fin_o, "R10 restart from finish", {busy_o, fin_o}, 2);
        wait_fin(n, 20);
        chk(n >= TMO - 1 && n <= TMO + 1, "R9 timeout window (R2 ignored start)", n + 1, TMO + 1);
        chk(fin_o && code_o == 2'd1, "R3 init-low timeout code", code_o, 1);
        chk(prog_n_o, "R3 program high at end", prog_n_o, 1);

        // ---- init falls but never rises ----
        pulse_start();
        repeat (2) @(negedge clk);
        cfg_init_i = 1'b0;
        wait_fin(n, 0);
        chk(fin_o && code_o == 2'd2, "R4 init-high timeout code", code_o, 2);
        chk(n >= TMO - 1 && n <= TMO + 2, "R9 second wait window", n, TMO);
        cfg_init_i = 1'b1;

        // ---- data sent, done never rises ----
        pulse_start();
        cfg_init_i = 1'b0;
        @(negedge clk);
        cfg_init_i = 1'b1;
        ncap = 0; step_err = 0;
        send_word(8'h5A, 1'b1);
        wait_fin(n, 0);
        chk(fin_o && code_o == 2'd3, "R8 done timeout code", code_o, 3);
        for (int k = 0; k < W; k++) got[W-1-k] = cap[k];
        chk(ncap == W && got == 8'h5A, "R6 single last word", got, 8'h5A);
        chk(step_err == 0, "R5 pattern second run", step_err, 0);
        chk(prog_n_o && cclk_o && din_o && !busy_o, "R1 pins after finish",
            {prog_n_o, cclk_o, din_o, busy_o}, 14);

        finish_up();
    end
endmodule